// File: doc/BRIEF.md
# PLL Acquisition Boost Controller

This block runs a temporary high-gain acquisition phase for a frequency synthesizer. A kick bit, written through the synthesizer's serial register interface, starts the boost. While the boost is active, the charge pump runs at four times its normal current and an external loop-filter switch pin is pulled low. The R and N dividers can also be told to run at a quarter of their ratio. When the boost ends, the block returns to 1x current, releases the pin to high impedance and restores the standard dividers.

Two configuration bits select one of four behaviours. The first chooses whether the boost ends by itself after a programmed number of phase-detector cycles, or stays on until software writes the kick bit back to zero. The second chooses whether the dividers are quartered while the boost is on. A master enable gates the whole function.

Every exit is taken on a phase-detector cycle strobe, never part-way through a comparison cycle. This keeps the charge on the loop filter undisturbed. Only two things drop the boost at once: clearing the master enable, and reset.

Top module: `acq_boost_ctrl`

## Requirements
- R1: With `boostEn` high, a serial write (`wrStrobe` high) with `wrKick`=1 sets `kickStatus` on that clock edge, and the boost becomes active on the following edge.
- R2: While the boost is active, `cpGain4x`=1 and `pinOe`=1, meaning the pin is driven low. Otherwise both are 0: 1x current and the pin at high impedance.
- R3: With `timeoutEn`=1, a write of 1 loads the count with `timeoutVal` (T). Each `pdStrobe` sampled while the boost is active decrements the count. On the (T+1)-th such strobe, `kickStatus` clears by itself and the boost ends on that same edge.
- R4: With `timeoutEn`=0, phase-detector strobes never end the boost, and `kickStatus` stays 1 until a serial write of 0.
- R5: `divScale` is 1 exactly while the boost is active and `divQuarter`=1.
- R6: A serial write of 0 clears `kickStatus` at once. The boost stays active until the next `pdStrobe` that is sampled after that write, and ends on that strobe's edge.
- R7: While `boostEn`=0, the kick bit has no effect on the outputs. `cpGain4x`, `pinOe` and `divScale` are 0 one edge after `boostEn` is sampled low, and the count does not advance. The stored kick bit is kept and starts the boost once `boostEn` returns high.
- R8: With `timeoutEn`=1 and `timeoutVal`=0, the boost ends on the first active `pdStrobe`.
- R9: A write of 1 while the boost is active reloads the count with `timeoutVal`, which extends the boost.
- R10: A synchronous active-high `rst` clears the kick bit and the count and forces normal outputs on the next edge.
- R11: `kickStatus` reads back the stored kick bit. It shows an automatic clear on the same edge as the timed exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrStrobe | input | 1 | One-clock pulse when the serial interface writes the kick bit |
| wrKick | input | 1 | Value of the kick bit carried by that write |
| boostEn | input | 1 | Master enable for the acquisition boost |
| timeoutEn | input | 1 | 1 = boost ends by itself after the count; 0 = boost ends on a serial write of 0 |
| divQuarter | input | 1 | 1 = quarter divider ratios during the boost |
| timeoutVal | input | CNT_W | Phase-detector cycle count for the timed exit |
| pdStrobe | input | 1 | One-clock pulse per phase-detector reference cycle |
| cpGain4x | output | 1 | Charge-pump current select: 1 = 4x, 0 = 1x |
| pinOe | output | 1 | Drive enable for the loop-filter pin (driven low when 1, high impedance when 0) |
| divScale | output | 1 | Tells the R and N dividers to use quarter ratios |
| kickStatus | output | 1 | Readback of the kick bit |

## Verification
The bench builds the block with the default count width of six bits, so any timeout from 0 to 63 can be programmed. Small values (0, 1, 2, 3) keep each timed exit within a few strobes, which lets the table reach the zero-count case, a reload just before expiry, and a normal expiry. The same build also covers the manual-exit path with quartered dividers and the gating by the master enable.

// File: rtl/acq_boost_pkg.sv
package acq_boost_pkg;
  // Strobes sent from the control module to the count datapath.
  typedef struct packed {
    logic load;  // load the count with the programmed timeout
    logic dec;   // step the count down by one
  } cntCmd_t;
endpackage

// File: rtl/acq_boost_dp.sv
module acq_boost_dp
  import acq_boost_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  cntCmd_t          cmd,
  input  logic [CNT_W-1:0] loadVal,
  output logic             cntZero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (cmd.load) cnt <= loadVal;
    else if (cmd.dec)  cnt <= cnt - ONE;
  end

  assign cntZero = (cnt == '0);
endmodule

// File: rtl/acq_boost_fsm.sv
module acq_boost_fsm
  import acq_boost_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    wrStrobe,
  input  logic    wrKick,
  input  logic    boostEn,
  input  logic    timeoutEn,
  input  logic    pdStrobe,
  input  logic    cntZero,
  output cntCmd_t cmd,
  output logic    active,
  output logic    kick
);
  logic kickQ, activeQ;
  logic wrSet, tick, expire, kickNext, activeNext;

  always_comb begin
    wrSet  = wrStrobe & wrKick;
    // A phase-detector strobe only counts while the boost is running.
    tick   = activeQ & pdStrobe & boostEn;
    // A rewrite of 1 in the same cycle wins over expiry.
    expire = tick & timeoutEn & cntZero & ~wrSet;

    if (wrStrobe)    kickNext = wrKick;
    else if (expire) kickNext = 1'b0;
    else             kickNext = kickQ;

    if (!boostEn)     activeNext = 1'b0;
    else if (activeQ) activeNext = ~(tick & (~kickQ | expire));
    else              activeNext = kickQ;

    cmd.load = wrSet;
    cmd.dec  = tick & timeoutEn & ~cntZero & ~wrSet;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kickQ   <= 1'b0;
      activeQ <= 1'b0;
    end else begin
      kickQ   <= kickNext;
      activeQ <= activeNext;
    end
  end

  assign active = activeQ;
  assign kick   = kickQ;
endmodule

// File: rtl/acq_boost_ctrl.sv
module acq_boost_ctrl
  import acq_boost_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrStrobe,
  input  logic             wrKick,
  input  logic             boostEn,
  input  logic             timeoutEn,
  input  logic             divQuarter,
  input  logic [CNT_W-1:0] timeoutVal,
  input  logic             pdStrobe,
  output logic             cpGain4x,
  output logic             pinOe,
  output logic             divScale,
  output logic             kickStatus
);
  cntCmd_t cmd;
  logic    cntZero, active, kick;

  acq_boost_fsm i_fsm (
    .clk(clk), .rst(rst), .wrStrobe(wrStrobe), .wrKick(wrKick),
    .boostEn(boostEn), .timeoutEn(timeoutEn), .pdStrobe(pdStrobe),
    .cntZero(cntZero), .cmd(cmd), .active(active), .kick(kick)
  );

  acq_boost_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rst(rst), .cmd(cmd), .loadVal(timeoutVal), .cntZero(cntZero)
  );

  assign cpGain4x   = active;
  assign pinOe      = active;
  assign divScale   = active & divQuarter;
  assign kickStatus = kick;
endmodule

// File: rtl/acq_boost_chk.sv
module acq_boost_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             wrStrobe,
  input logic             wrKick,
  input logic             boostEn,
  input logic             timeoutEn,
  input logic             divQuarter,
  input logic [CNT_W-1:0] timeoutVal,
  input logic             pdStrobe,
  input logic             cpGain4x,
  input logic             pinOe,
  input logic             divScale,
  input logic             kickStatus
);
  AST_ENTRY_NEEDS_KICK: assert property (@(posedge clk) disable iff (rst)
    $rose(cpGain4x) |-> ($past(kickStatus) && $past(boostEn))); // R1

  AST_TIMED_CLEAR_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    $fell(kickStatus) |-> ($past(wrStrobe) || $past(rst) ||
                           ($past(timeoutEn) && $past(pdStrobe)))); // R3

  AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (kickStatus && !timeoutEn && !wrStrobe) |=> kickStatus); // R4

  AST_EXIT_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    $fell(cpGain4x) |-> ($past(pdStrobe) || !$past(boostEn) || $past(rst))); // R6

  AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (rst)
    !boostEn |=> (!cpGain4x && !divScale)); // R7

  AST_RESET_NORMAL: assert property (@(posedge clk)
    rst |=> (!cpGain4x && !pinOe && !kickStatus)); // R10
endmodule

bind acq_boost_ctrl acq_boost_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_acq_boost_ctrl.sv
module test_acq_boost_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 6;
  localparam int NVEC       = 29;
  localparam int WATCHDOG   = 5000;

  // Row layout: wr kick pd en to dq T[5:0] | expGain expDiv expStatus
  localparam logic [14:0] VEC [NVEC] = '{
    15'b0_0_0_1_1_0_000010_0_0_0,  // 0  idle
    15'b1_1_0_1_1_0_000010_0_0_1,  // 1  R1 write kick, T=2
    15'b0_0_0_1_1_0_000010_1_0_1,  // 2  R1 active
    15'b0_0_1_1_1_0_000010_1_0_1,  // 3  R3 strobe 1
    15'b0_0_1_1_1_0_000010_1_0_1,  // 4  R3 strobe 2
    15'b0_0_0_1_1_0_000010_1_0_1,  // 5
    15'b0_0_1_1_1_0_000010_0_0_0,  // 6  R3 R11 strobe 3 expires
    15'b0_0_0_1_1_0_000010_0_0_0,  // 7  stays idle
    15'b1_1_0_1_0_1_000000_0_0_1,  // 8  R4 manual, quarter
    15'b0_0_1_1_0_1_000000_1_1_1,  // 9  R5 enters
    15'b0_0_1_1_0_1_000000_1_1_1,  // 10 R4 strobe no exit
    15'b0_0_1_1_0_1_000000_1_1_1,  // 11 R4
    15'b1_0_0_1_0_1_000000_1_1_0,  // 12 R6 write 0, still active
    15'b0_0_0_1_0_1_000000_1_1_0,  // 13 R6 waits for strobe
    15'b0_0_1_1_0_1_000000_0_0_0,  // 14 R6 exit on strobe
    15'b1_1_0_1_1_1_000000_0_0_1,  // 15 R8 T=0
    15'b0_0_0_1_1_1_000000_1_1_1,  // 16 R8 active
    15'b0_0_1_1_1_1_000000_0_0_0,  // 17 R8 first strobe exits
    15'b1_1_0_1_1_0_000001_0_0_1,  // 18 R9 T=1
    15'b0_0_0_1_1_0_000001_1_0_1,  // 19
    15'b0_0_1_1_1_0_000001_1_0_1,  // 20 count 1->0
    15'b1_1_0_1_1_0_000001_1_0_1,  // 21 R9 reload
    15'b0_0_1_1_1_0_000001_1_0_1,  // 22 R9 would have expired
    15'b0_0_1_1_1_0_000001_0_0_0,  // 23 R9 expires now
    15'b1_1_0_0_1_0_000011_0_0_1,  // 24 R7 disabled write
    15'b0_0_0_0_1_0_000011_0_0_1,  // 25 R7 no effect
    15'b0_0_1_0_1_0_000011_0_0_1,  // 26 R7 strobe ignored
    15'b0_0_0_1_1_0_000011_1_0_1,  // 27 R7 re-enable starts boost
    15'b0_0_0_0_1_0_000011_0_0_1   // 28 R7 disable drops at once
  };

  logic clk = 1'b0;
  logic rst, wrStrobe, wrKick, boostEn, timeoutEn, divQuarter, pdStrobe;
  logic [CNT_W-1:0] timeoutVal;
  logic cpGain4x, pinOe, divScale, kickStatus;
  int   nChecks = 0;
  int   nFails  = 0;
  bit   finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acq_boost_ctrl #(.CNT_W(CNT_W)) i_acq_boost_ctrl (
    .clk(clk), .rst(rst), .wrStrobe(wrStrobe), .wrKick(wrKick),
    .boostEn(boostEn), .timeoutEn(timeoutEn), .divQuarter(divQuarter),
    .timeoutVal(timeoutVal), .pdStrobe(pdStrobe),
    .cpGain4x(cpGain4x), .pinOe(pinOe), .divScale(divScale),
    .kickStatus(kickStatus)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {gain,pin,div,status} actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic string reqOf(input int i);
    if (i <= 2)  return "R1";
    if (i <= 7)  return "R3";
    if (i <= 11) return "R4_R5";
    if (i <= 14) return "R6";
    if (i <= 17) return "R8";
    if (i <= 23) return "R9";
    return "R7";
  endfunction

  task automatic applyIdle();
    wrStrobe = 0; wrKick = 0; pdStrobe = 0;
  endtask

  initial begin
    rst = 1; applyIdle(); boostEn = 1; timeoutEn = 1; divQuarter = 0; timeoutVal = '0;
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R10_reset_state", {cpGain4x, pinOe, divScale, kickStatus}, 4'b0000);
    @(negedge clk) rst = 0;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {wrStrobe, wrKick, pdStrobe, boostEn, timeoutEn, divQuarter} = VEC[i][14:9];
      timeoutVal = VEC[i][8:3];
      @(posedge clk);
      #(CLK_PERIOD/4);
      // R2: pin drive follows the current select; R11: status readback
      check(reqOf(i), {cpGain4x, pinOe, divScale, kickStatus},
            {VEC[i][2], VEC[i][2], VEC[i][1], VEC[i][0]});
    end

    // R10: reset while the kick bit is stored clears it
    @(negedge clk) begin applyIdle(); boostEn = 1; rst = 1; end
    @(posedge clk); #(CLK_PERIOD/4);
    check("R10_reset_clears", {cpGain4x, pinOe, divScale, kickStatus}, 4'b0000);
    @(negedge clk) rst = 0;
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R10_no_restart", {cpGain4x, pinOe, divScale, kickStatus}, 4'b0000);

    // R10: reset in mid-boost forces normal outputs on the next edge
    @(negedge clk) begin wrStrobe = 1; wrKick = 1; timeoutEn = 0; divQuarter = 1; end
    @(negedge clk) applyIdle();
    @(posedge clk); #(CLK_PERIOD/4);
    check("R5_boost_up", {cpGain4x, pinOe, divScale, kickStatus}, 4'b1111);
    @(negedge clk) rst = 1;
    @(posedge clk); #(CLK_PERIOD/4);
    check("R10_mid_boost", {cpGain4x, pinOe, divScale, kickStatus}, 4'b0000);
    @(negedge clk) rst = 0;

    // R3: longest count of 63 needs 64 active strobes
    @(negedge clk) begin wrStrobe = 1; wrKick = 1; timeoutEn = 1; divQuarter = 0;
                         timeoutVal = 6'd63; end
    @(negedge clk) applyIdle();
    @(negedge clk);
    for (int s = 0; s < 63; s++) begin
      pdStrobe = 1;
      @(negedge clk);
    end
    pdStrobe = 0;
    check("R3_63_still_on", {cpGain4x, pinOe, divScale, kickStatus}, 4'b1101);
    pdStrobe = 1;
    @(negedge clk) pdStrobe = 0;
    check("R3_64th_exit", {cpGain4x, pinOe, divScale, kickStatus}, 4'b0000);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule